// File: doc/BRIEF.md
# Gate Scan Clock Sequencer

This block drives the vertical gate clock of an e-paper panel. It also orders the updates of four panel control flags for the four commands a host state machine can issue: begin a frame, drive one row, skip one row, and end a frame. A single timer makes every gate-clock pulse. Each pulse has a high time and a low time, both counted in clock cycles and derived from two parameters. One parameter is the number of cycles in a microsecond. The other is the number of cycles in one timer tick.

Flag updates are not written to the panel directly. For each update the block raises a request to an external configuration serializer and presents the complete flag set with it. It then holds both until the serializer acknowledges. Begin-frame and row commands first wait for the row data streamer to report that it is idle. After the gate pulse of a row, the block sends the streamer two strobes: one to start the next line and one to swap buffers.

A command is accepted only when the block is idle. A command that arrives while another is running is refused with a one-cycle reject pulse. When a command has finished, a one-cycle done pulse is raised.

Top module: `gate_scan_sequencer`

## Requirements
- R1: Begin-frame (cmd_op 0) runs these steps in order. Wait for the streamer to be idle. Set drive-mode and push. Pulse 1 us high and 1 us low. Clear scan-start and push. Wait 1 us. Pulse 10 us high and 10 us low, with gate output enable still clear. Set scan-start and push. Hold low for 10 us with no high phase. Set gate output enable and push. Pulse 1 us high and 1 us low.
- R2: Row (cmd_op 1) runs these steps in order. Wait for the streamer to be idle. Set row-latch and push. Clear row-latch and push. Pulse cmd_row_ticks ticks high and 50 ticks low. Then raise line_start and buf_swap together for exactly one cycle.
- R3: Skip (cmd_op 2) makes one pulse of 45 ticks high and 5 ticks low, with no flag push.
- R4: End-frame (cmd_op 3) runs these steps in order. Clear gate output enable and push. Clear drive-mode and push. Make two pulses of 1 us high and 1 us low each.
- R5: cfg_flags always shows the full flag set: bit 0 is row-latch, bit 1 is scan-start, bit 2 is drive-mode and bit 3 is gate output enable. A push raises cfg_req in the same cycle as the new cfg_flags value. cfg_req and cfg_flags stay unchanged until cfg_ack is sampled high. cfg_req falls in the next cycle.
- R6: Each step begins one cycle after the previous step ends. A pulse with high time H starts its high phase in its first cycle, and that phase lasts exactly H cycles. A low time L keeps gate_clk low for L cycles before the step ends. A push ends on the edge at which cfg_ack is sampled. A command begins its first step one cycle after it is accepted.
- R7: A pulse whose high time is zero produces no rising edge on gate_clk. Only its low phase runs.
- R8: Begin-frame and row do not start their first push until line_busy has been sampled low. The wait ends on the first edge, one cycle or more after the wait begins, at which line_busy is low.
- R9: done is a one-cycle pulse. It rises one cycle after the last step ends. busy is high from the cycle after acceptance until done, and low once done has been raised.
- R10: A cmd_valid sampled while busy gives cmd_reject one cycle later and has no effect on the running command or on any later output.
- R11: While reset is high and after it is released, gate_clk, cfg_req, busy and done are low and cfg_flags is 4'b0010 (scan-start set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 begin-frame, 1 row, 2 skip, 3 end-frame |
| cmd_row_ticks | input | ROW_W | Row gate-pulse high time in ticks |
| cmd_reject | output | 1 | Command refused because busy |
| busy | output | 1 | A command is running |
| done | output | 1 | Command finished |
| line_busy | input | 1 | Row data streamer still shifting |
| line_start | output | 1 | Start next line strobe |
| buf_swap | output | 1 | Swap line buffers strobe |
| cfg_req | output | 1 | Flag push request |
| cfg_flags | output | 4 | Full flag set to serialize |
| cfg_ack | input | 1 | Push complete |
| gate_clk | output | 1 | Vertical gate clock |

## Verification
The bench builds the block with 4 cycles per microsecond, 2 cycles per tick and a 6-bit row time. With these values every step of a begin-frame fits in well under a hundred cycles. Every row high time from zero to the full 63 ticks can be run and timed edge by edge. Acknowledge latencies of one to three cycles and a delayed streamer release move the step boundaries. This checks the one-cycle turnaround between steps against timestamps the bench computes itself.

// File: rtl/gss_pkg.sv
`timescale 1ns/1ps
package gss_pkg;

  typedef enum logic [1:0] {
    OP_FRAME_BEGIN = 2'd0,
    OP_ROW         = 2'd1,
    OP_SKIP        = 2'd2,
    OP_FRAME_END   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    K_WAIT   = 3'd0,
    K_PUSH   = 3'd1,
    K_PULSE  = 3'd2,
    K_STROBE = 3'd3,
    K_DONE   = 3'd4
  } kind_e;

  localparam int NFLAG = 4;
  localparam logic [1:0] FL_LATCH = 2'd0;
  localparam logic [1:0] FL_SCAN  = 2'd1;
  localparam logic [1:0] FL_MODE  = 2'd2;
  localparam logic [1:0] FL_OE    = 2'd3;
  localparam logic [NFLAG-1:0] FLAGS_RST = 4'b0010;

  localparam int IDX_W = 4;

endpackage

// File: rtl/gss_step_rom.sv
`timescale 1ns/1ps
module gss_step_rom
  import gss_pkg::*;
#(
  parameter int CYC_PER_US = 240,
  parameter int TICK_CYC   = 24,
  parameter int ROW_W      = 16,
  parameter int CNT_W      = 21
) (
  input  op_e              op,
  input  logic [IDX_W-1:0] idx,
  input  logic [ROW_W-1:0] row_ticks,
  output kind_e            kind,
  output logic [1:0]       fbit,
  output logic             fval,
  output logic [CNT_W-1:0] hi_cyc,
  output logic [CNT_W-1:0] lo_cyc
);

  localparam logic [CNT_W-1:0] C_1US    = CNT_W'(CYC_PER_US);
  localparam logic [CNT_W-1:0] C_10US   = CNT_W'(10 * CYC_PER_US);
  localparam logic [CNT_W-1:0] C_SKP_HI = CNT_W'(45 * TICK_CYC);
  localparam logic [CNT_W-1:0] C_SKP_LO = CNT_W'(5 * TICK_CYC);
  localparam logic [CNT_W-1:0] C_ROW_LO = CNT_W'(50 * TICK_CYC);
  localparam logic [CNT_W-1:0] C_TICK   = CNT_W'(TICK_CYC);

  logic [CNT_W-1:0] row_hi;
  assign row_hi = CNT_W'(row_ticks) * C_TICK;

  always_comb begin
    kind   = K_DONE;
    fbit   = FL_LATCH;
    fval   = 1'b0;
    hi_cyc = '0;
    lo_cyc = CNT_W'(1);
    case (op)
      OP_FRAME_BEGIN: begin
        case (idx)
          4'd0: kind = K_WAIT;
          4'd1: begin kind = K_PUSH; fbit = FL_MODE; fval = 1'b1; end
          4'd2: begin kind = K_PULSE; hi_cyc = C_1US; lo_cyc = C_1US; end
          4'd3: begin kind = K_PUSH; fbit = FL_SCAN; fval = 1'b0; end
          4'd4: begin kind = K_PULSE; hi_cyc = '0; lo_cyc = C_1US; end
          4'd5: begin kind = K_PULSE; hi_cyc = C_10US; lo_cyc = C_10US; end
          4'd6: begin kind = K_PUSH; fbit = FL_SCAN; fval = 1'b1; end
          4'd7: begin kind = K_PULSE; hi_cyc = '0; lo_cyc = C_10US; end
          4'd8: begin kind = K_PUSH; fbit = FL_OE; fval = 1'b1; end
          4'd9: begin kind = K_PULSE; hi_cyc = C_1US; lo_cyc = C_1US; end
          default: kind = K_DONE;
        endcase
      end
      OP_ROW: begin
        case (idx)
          4'd0: kind = K_WAIT;
          4'd1: begin kind = K_PUSH; fbit = FL_LATCH; fval = 1'b1; end
          4'd2: begin kind = K_PUSH; fbit = FL_LATCH; fval = 1'b0; end
          4'd3: begin kind = K_PULSE; hi_cyc = row_hi; lo_cyc = C_ROW_LO; end
          4'd4: kind = K_STROBE;
          default: kind = K_DONE;
        endcase
      end
      OP_SKIP: begin
        case (idx)
          4'd0: begin kind = K_PULSE; hi_cyc = C_SKP_HI; lo_cyc = C_SKP_LO; end
          default: kind = K_DONE;
        endcase
      end
      default: begin
        case (idx)
          4'd0: begin kind = K_PUSH; fbit = FL_OE; fval = 1'b0; end
          4'd1: begin kind = K_PUSH; fbit = FL_MODE; fval = 1'b0; end
          4'd2: begin kind = K_PULSE; hi_cyc = C_1US; lo_cyc = C_1US; end
          4'd3: begin kind = K_PULSE; hi_cyc = C_1US; lo_cyc = C_1US; end
          default: kind = K_DONE;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/gss_pulse_timer.sv
`timescale 1ns/1ps
module gss_pulse_timer #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] hi_cyc,
  input  logic [CNT_W-1:0] lo_cyc,
  output logic             pulse_out,
  output logic             last
);

  typedef enum logic [1:0] {T_IDLE, T_HI, T_LO} tstate_e;

  tstate_e          st;
  logic [CNT_W-1:0] cnt;

  assign last = (st == T_LO) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= T_IDLE;
      cnt       <= '0;
      pulse_out <= 1'b0;
    end else begin
      case (st)
        T_IDLE: begin
          if (start) begin
            if (hi_cyc != '0) begin
              st        <= T_HI;
              cnt       <= hi_cyc - CNT_W'(1);
              pulse_out <= 1'b1;
            end else begin
              st        <= T_LO;
              cnt       <= lo_cyc - CNT_W'(1);
              pulse_out <= 1'b0;
            end
          end
        end
        T_HI: begin
          if (cnt == '0) begin
            st        <= T_LO;
            cnt       <= lo_cyc - CNT_W'(1);
            pulse_out <= 1'b0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        T_LO: begin
          if (cnt == '0) st <= T_IDLE;
          else           cnt <= cnt - CNT_W'(1);
        end
        default: st <= T_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gate_scan_sequencer.sv
`timescale 1ns/1ps
module gate_scan_sequencer
  import gss_pkg::*;
#(
  parameter int CYC_PER_US = 240,
  parameter int TICK_CYC   = 24,
  parameter int ROW_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [ROW_W-1:0] cmd_row_ticks,
  output logic             cmd_reject,
  output logic             busy,
  output logic             done,
  input  logic             line_busy,
  output logic             line_start,
  output logic             buf_swap,
  output logic             cfg_req,
  output logic [3:0]       cfg_flags,
  input  logic             cfg_ack,
  output logic             gate_clk
);

  localparam int MAX_US  = 10 * CYC_PER_US;
  localparam int MAX_ROW = ((1 << ROW_W) - 1) * TICK_CYC;
  localparam int MAX_TK  = 50 * TICK_CYC;
  localparam int MAX_A   = (MAX_US > MAX_ROW) ? MAX_US : MAX_ROW;
  localparam int MAX_ALL = (MAX_A > MAX_TK) ? MAX_A : MAX_TK;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_EXEC} sstate_e;

  sstate_e          state;
  op_e              op_q;
  logic [ROW_W-1:0] row_q;
  logic [IDX_W-1:0] idx;
  logic [3:0]       flags;

  kind_e            kind;
  logic [1:0]       fbit;
  logic             fval;
  logic [CNT_W-1:0] hi_cyc;
  logic [CNT_W-1:0] lo_cyc;
  logic             tm_start;
  logic             tm_last;

  gss_step_rom #(
    .CYC_PER_US(CYC_PER_US),
    .TICK_CYC  (TICK_CYC),
    .ROW_W     (ROW_W),
    .CNT_W     (CNT_W)
  ) u_rom (
    .op       (op_q),
    .idx      (idx),
    .row_ticks(row_q),
    .kind     (kind),
    .fbit     (fbit),
    .fval     (fval),
    .hi_cyc   (hi_cyc),
    .lo_cyc   (lo_cyc)
  );

  assign tm_start = (state == S_ISSUE) && (kind == K_PULSE);

  gss_pulse_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .start    (tm_start),
    .hi_cyc   (hi_cyc),
    .lo_cyc   (lo_cyc),
    .pulse_out(gate_clk),
    .last     (tm_last)
  );

  assign busy      = (state != S_IDLE);
  assign cfg_flags = flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      op_q       <= OP_FRAME_BEGIN;
      row_q      <= '0;
      idx        <= '0;
      flags      <= FLAGS_RST;
      cfg_req    <= 1'b0;
      cmd_reject <= 1'b0;
      done       <= 1'b0;
      line_start <= 1'b0;
      buf_swap   <= 1'b0;
    end else begin
      cmd_reject <= cmd_valid && (state != S_IDLE);
      done       <= 1'b0;
      line_start <= 1'b0;
      buf_swap   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q  <= op_e'(cmd_op);
            row_q <= cmd_row_ticks;
            idx   <= '0;
            state <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          case (kind)
            K_WAIT:  state <= S_EXEC;
            K_PUSH: begin
              flags[fbit] <= fval;
              cfg_req     <= 1'b1;
              state       <= S_EXEC;
            end
            K_PULSE: state <= S_EXEC;
            K_STROBE: begin
              line_start <= 1'b1;
              buf_swap   <= 1'b1;
              idx        <= idx + IDX_W'(1);
            end
            default: begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
          endcase
        end
        S_EXEC: begin
          case (kind)
            K_WAIT: begin
              if (!line_busy) begin
                idx   <= idx + IDX_W'(1);
                state <= S_ISSUE;
              end
            end
            K_PUSH: begin
              if (cfg_ack) begin
                cfg_req <= 1'b0;
                idx     <= idx + IDX_W'(1);
                state   <= S_ISSUE;
              end
            end
            K_PULSE: begin
              if (tm_last) begin
                idx   <= idx + IDX_W'(1);
                state <= S_ISSUE;
              end
            end
            default: state <= S_ISSUE;
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gss_checker.sv
`timescale 1ns/1ps
module gss_checker (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_reject,
  input logic       busy,
  input logic       done,
  input logic       line_start,
  input logic       buf_swap,
  input logic       cfg_req,
  input logic [3:0] cfg_flags,
  input logic       cfg_ack,
  input logic       gate_clk
);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_req && !cfg_ack |=> cfg_req);

  p_flags_hold_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_req && !cfg_ack |=> $stable(cfg_flags));

  p_req_drop_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_req && cfg_ack |=> !cfg_req);

  p_no_push_in_high_r6: assert property (@(posedge clk) disable iff (rst)
    gate_clk |-> !$rose(cfg_req));

  p_quiet_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !gate_clk && !cfg_req);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start && !buf_swap);

  p_reject_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && busy |=> cmd_reject);

  p_accept_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !busy |=> busy && !cmd_reject);

endmodule

bind gate_scan_sequencer gss_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_reject(cmd_reject),
  .busy      (busy),
  .done      (done),
  .line_start(line_start),
  .buf_swap  (buf_swap),
  .cfg_req   (cfg_req),
  .cfg_flags (cfg_flags),
  .cfg_ack   (cfg_ack),
  .gate_clk  (gate_clk)
);

// File: tb/gate_scan_sequencer_tb.sv
`timescale 1ns/1ps
module gate_scan_sequencer_tb;

  localparam int US  = 4;
  localparam int TK  = 2;
  localparam int RW  = 6;
  localparam int EVN = 128;

  localparam int EV_RISE = 1, EV_FALL = 2, EV_REQ = 3, EV_ACK = 4, EV_STRB = 5, EV_DONE = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [RW-1:0] cmd_row_ticks = '0;
  logic          cmd_reject, busy, done, line_start, buf_swap, cfg_req, gate_clk;
  logic [3:0]    cfg_flags;
  logic          line_busy = 1'b0;
  logic          cfg_ack = 1'b0;

  always #2 clk = ~clk;

  gate_scan_sequencer #(.CYC_PER_US(US), .TICK_CYC(TK), .ROW_W(RW)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_row_ticks(cmd_row_ticks), .cmd_reject(cmd_reject), .busy(busy),
    .done(done), .line_busy(line_busy), .line_start(line_start),
    .buf_swap(buf_swap), .cfg_req(cfg_req), .cfg_flags(cfg_flags),
    .cfg_ack(cfg_ack), .gate_clk(gate_clk)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ev_k [EVN];
  int ev_t [EVN];
  int ev_d [EVN];
  int nev = 0;
  int p = 0;
  int t_end = 0;
  int rel_t = 0;
  int rej_n = 0;
  int ack_lat = 1;
  int wcnt = 0;
  bit done_seen = 0;
  logic ckv_q = 1'b0, req_q = 1'b0;
  logic [3:0] exp_flags = 4'b0010;
  int n_chk = 0, n_fail = 0;

  task automatic log_ev(int k, int t, int d);
    if (nev < EVN) begin
      ev_k[nev] = k; ev_t[nev] = t; ev_d[nev] = d; nev++;
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (gate_clk && !ckv_q) log_ev(EV_RISE, cyc, 0);
      if (!gate_clk && ckv_q) log_ev(EV_FALL, cyc, 0);
      if (cfg_req && !req_q) log_ev(EV_REQ, cyc, int'(cfg_flags));
      if (line_start || buf_swap) log_ev(EV_STRB, cyc, int'({line_start, buf_swap}));
      if (done) begin log_ev(EV_DONE, cyc, 0); done_seen = 1; end
      if (cmd_reject) rej_n++;
      if (cfg_ack) cfg_ack = 1'b0;
      else if (cfg_req) begin
        wcnt++;
        if (wcnt >= ack_lat) begin
          cfg_ack = 1'b1;
          wcnt = 0;
          log_ev(EV_ACK, cyc + 1, 0);
        end
      end
    end
    ckv_q = gate_clk;
    req_q = cfg_req;
  end

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic take(int k, int t, int d, string rq, string what);
    if (p >= nev) chk(1'b0, rq, {what, " missing"}, -1, k);
    else begin
      chk(ev_k[p] == k, rq, {what, " kind"}, ev_k[p], k);
      if (t >= 0) chk(ev_t[p] == t, rq, {what, " cycle"}, ev_t[p], t);
      chk(ev_d[p] == d, rq, {what, " data"}, ev_d[p], d);
      p++;
    end
  endtask

  // one gate pulse of h high, l low; zero h gives no edges
  task automatic s_pulse(int h, int l, string rq);
    if (h > 0) begin
      take(EV_RISE, t_end + 1, 0, rq, "rise");
      take(EV_FALL, t_end + 1 + h, 0, rq, "fall");
    end
    t_end = t_end + 1 + h + l;
  endtask

  task automatic s_push(int b, bit v, string rq);
    exp_flags[b] = v;
    take(EV_REQ, t_end + 1, int'(exp_flags), rq, "flag push");
    if (p < nev && ev_k[p] == EV_ACK) t_end = ev_t[p];
    take(EV_ACK, -1, 0, rq, "ack");
  endtask

  task automatic s_wait();
    t_end = (t_end + 2 > rel_t) ? t_end + 2 : rel_t;
  endtask

  task automatic s_strobe(string rq);
    take(EV_STRB, t_end + 1, 3, rq, "line strobes");
    t_end = t_end + 1;
  endtask

  task automatic s_done(string rq);
    take(EV_DONE, t_end + 1, 0, rq, "done");
    t_end = t_end + 1;
  endtask

  // launch a command; hold line_busy for hold cycles; inject a refused command at rej_at
  task automatic run_cmd(int op, int row, int hold, int rej_at);
    @(negedge clk);
    nev = 0; p = 0; done_seen = 0; rej_n = 0; rel_t = 0;
    if (hold > 0) line_busy = 1'b1;
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_row_ticks = RW'(row);
    t_end = cyc + 1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
    for (int k = 1; k < 3000 && !done_seen; k++) begin
      if (hold > 0 && k == hold) begin line_busy = 1'b0; rel_t = cyc + 1; end
      if (k == rej_at) begin cmd_valid = 1'b1; cmd_op = 2'd3; end
      else cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    if (!done_seen) chk(1'b0, "R9", "watchdog: command never finished", 0, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R9", "busy after done", int'(busy), 0);
  endtask

  task automatic no_extra(string rq);
    repeat (20) @(negedge clk);
    chk(p == nev, rq, "no extra events", nev, p);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(gate_clk == 1'b0 && cfg_req == 1'b0, "R11", "outputs in reset", int'({gate_clk, cfg_req}), 0);
    chk(cfg_flags == 4'b0010, "R11", "flags in reset", int'(cfg_flags), 2);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R11", "idle after reset", int'({busy, done}), 0);
    chk(cfg_flags == 4'b0010, "R11", "flags after reset", int'(cfg_flags), 2);

    // R1 + R8: begin-frame with streamer held busy for 9 cycles
    ack_lat = 1;
    run_cmd(0, 0, 9, -1);
    s_wait();
    s_push(2, 1'b1, "R1");
    s_pulse(US, US, "R1");
    s_push(1, 1'b0, "R1");
    s_pulse(0, US, "R1");
    s_pulse(10 * US, 10 * US, "R1");
    chk(exp_flags[3] == 1'b0, "R1", "gate oe clear in long pulse", int'(exp_flags[3]), 0);
    s_push(1, 1'b1, "R7");
    s_pulse(0, 10 * US, "R7");
    s_push(3, 1'b1, "R1");
    s_pulse(US, US, "R1");
    s_done("R9");
    no_extra("R1");

    // R2: rows, streamer release delays, R7 zero high time, full range
    ack_lat = 2;
    run_cmd(1, 5, 0, -1);
    s_wait(); s_push(0, 1'b1, "R2"); s_push(0, 1'b0, "R2");
    s_pulse(5 * TK, 50 * TK, "R2"); s_strobe("R2"); s_done("R2");
    no_extra("R2");

    run_cmd(1, 0, 0, -1);
    s_wait(); s_push(0, 1'b1, "R2"); s_push(0, 1'b0, "R2");
    s_pulse(0, 50 * TK, "R7"); s_strobe("R7"); s_done("R7");
    no_extra("R7");

    ack_lat = 3;
    run_cmd(1, 63, 30, -1);
    s_wait(); s_push(0, 1'b1, "R8"); s_push(0, 1'b0, "R8");
    s_pulse(63 * TK, 50 * TK, "R2"); s_strobe("R2"); s_done("R2");
    no_extra("R8");

    for (int r = 1; r <= 12; r++) begin
      ack_lat = 1 + (r % 3);
      run_cmd(1, r, r % 4, -1);
      s_wait(); s_push(0, 1'b1, "R5"); s_push(0, 1'b0, "R5");
      s_pulse(r * TK, 50 * TK, "R6"); s_strobe("R2"); s_done("R9");
      no_extra("R2");
    end

    // R3 + R10: skip with a refused command in the middle
    run_cmd(2, 0, 0, 20);
    s_pulse(45 * TK, 5 * TK, "R3"); s_done("R3");
    no_extra("R10");
    chk(rej_n == 1, "R10", "reject pulses", rej_n, 1);
    chk(cfg_flags == exp_flags, "R10", "flags untouched by refused command", int'(cfg_flags), int'(exp_flags));

    // R4: end-frame
    ack_lat = 3;
    run_cmd(3, 0, 0, -1);
    s_push(3, 1'b0, "R4"); s_push(2, 1'b0, "R4");
    s_pulse(US, US, "R4"); s_pulse(US, US, "R4"); s_done("R4");
    no_extra("R4");
    chk(cfg_flags == 4'b0010, "R4", "flags after end-frame", int'(cfg_flags), 2);

    finish_run();
  end

endmodule